// File: doc/BRIEF.md
# Four-Slot Interrupt Aggregation Controller

This block gathers two interrupt request lines from each of four plug-in module slots and merges them into a single host interrupt. Each of the eight sources has a status bit that follows its request line while the source is enabled. Each source can be set to edge mode, which gives a one-clock pulse when the status bit rises, or to level mode, which holds the host interrupt high for as long as the status bit stays set.

Software reaches the block through a small 16-bit register port: one 8-bit control register per slot and a shared 16-bit status word. Module status is never cleared by software directly. Writing a one to a module status bit, or strobing the acknowledge input of a set level-mode source, sends a one-clock clear strobe back to that module. The module then drops its request, and the status bit follows. Timeout flags are set by an external event input and cleared by writing a one to them. The error flags only mirror an external input.

Top module: `slot_irq_merge`

## Requirements
- R1: Status bit s*2+n (bits 0 to 7) holds the level of request line n of slot s. It is sampled at every clock edge while that line is enabled, and it is visible one cycle after the request changes.
- R2: The control register of slot s sits at byte offset 0x02+2*s and reads back the 8 bits last written. Bit 4+n selects edge mode for line n and bit 6+n enables line n. A write to any other offset leaves it unchanged.
- R3: Reset (synchronous, active low) clears every control register, every status bit and every clear strobe, and drives the host interrupt low.
- R4: While a line's enable bit is clear, changes on its request line are ignored and its status bit keeps its value.
- R5: An edge-mode source whose status bit rises drives the host interrupt high for exactly one cycle. Holding or dropping the request adds no further pulse.
- R6: The host interrupt is high in every cycle in which some status bit in bits 0 to 7 is set and its source is in level mode. It is low once none remains and no edge pulse is due.
- R7: Writing the status word at offset 0x0C with a one in bit s*2+n raises clear strobe s*2+n for one cycle, in the cycle after the write. The status bit itself is not changed by the write.
- R8: Timeout flag s is status bit 12+s. A pulse on the timeout event input s sets it. Writing a one to it clears it. Otherwise it holds its value.
- R9: Status bits 8 to 11 show the error flag inputs one cycle late. Writes to those bits have no effect.
- R10: An acknowledge strobe on source s*2+n raises its clear strobe in the next cycle only if that status bit is set and the source is in level mode.
- R11: Offset 0x00 reads 0 and ignores writes. Offset 0x0A and every unmapped offset read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| mod_req | input | 8 | Module request lines, index slot*2+line |
| ack_strobe | input | 8 | Acknowledge strobes, index slot*2+line |
| timeout_evt | input | 4 | Timeout event pulses, one per slot |
| err_flags | input | 4 | Error flag inputs |
| mod_clr | output | 8 | One-cycle clear strobes to the modules |
| host_irq | output | 1 | Merged host interrupt, registered |

## Verification
Status bits, timeout and error flags, clear strobes and the host interrupt each change at the first clock edge after their cause, so each result is due one cycle after its stimulus. Read data is combinational on the current state. The bench drives every stimulus on a falling edge and samples one falling edge later, which lies after exactly one rising edge. A clear strobe is checked both in the cycle it is due and in the cycle after, to confirm that it lasts one cycle. A control write that re-enables a line takes effect only from the following edge, so the bench waits a further cycle before it checks the status it expects.

// File: rtl/sia_pkg.sv
// Shared constants for the slot interrupt aggregation controller.
// Assumes a 16-bit register word and byte offsets on an 8-bit address.
package sia_pkg;
    localparam int SLOTS    = 4;
    localparam int LINES    = 2;
    localparam int SRC      = SLOTS * LINES;
    localparam int DATA_W   = 16;
    localparam int CTRL_W   = 8;
    localparam int ADDR_W   = 8;
    localparam int EDGE_LSB = 4;
    localparam int EN_LSB   = 6;
    localparam int ERR_LSB  = 8;
    localparam int ERR_W    = 4;
    localparam int TO_LSB   = 12;

    localparam logic [ADDR_W-1:0] OFF_CTRL0 = 8'h02;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 8'h0C;

    // Byte offset of the control register of slot s.
    function automatic logic [ADDR_W-1:0] ctrl_off(input int s);
        return OFF_CTRL0 + ADDR_W'(2 * s);
    endfunction
endpackage

// File: rtl/sia_ctrl_regs.sv
// Per-slot control registers.
// Stores one byte per slot and breaks out the enable and edge-mode bits
// as per-source masks indexed slot*LINES+line.
// Assumes the caller has already qualified wr with a legal access.
module sia_ctrl_regs
    import sia_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [CTRL_W-1:0]             wdata,
    output logic [SLOTS-1:0][CTRL_W-1:0]  ctrl_q,
    output logic [SRC-1:0]                en_mask,
    output logic [SRC-1:0]                edge_mask
);
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        // Capture a write addressed to this slot's control byte.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ctrl_q[s] <= '0;
            else if (wr && addr == ctrl_off(s))
                ctrl_q[s] <= wdata;
        end

        for (genvar n = 0; n < LINES; n++) begin : g_line
            assign en_mask[s*LINES+n]   = ctrl_q[s][EN_LSB+n];
            assign edge_mask[s*LINES+n] = ctrl_q[s][EDGE_LSB+n];
        end

        // R2: a control byte changes only when it is written
        p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr && addr == ctrl_off(s)) |=> $stable(ctrl_q[s]));
    end
endmodule

// File: rtl/sia_status.sv
// Status word and clear strobes.
// Module status bits follow enabled request lines. Timeout flags are set by
// event pulses and cleared by writing a one. Error flags mirror an input.
// Clear strobes come from status writes and from level-mode acknowledges.
// Assumes request, ack and event inputs are synchronous to clk.
module sia_status
    import sia_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SRC-1:0]    mod_req,
    input  logic [SRC-1:0]    en_mask,
    input  logic [SRC-1:0]    edge_mask,
    input  logic [SRC-1:0]    ack,
    input  logic [SLOTS-1:0]  timeout_evt,
    input  logic [ERR_W-1:0]  err_flags,
    output logic [SRC-1:0]    st_q,
    output logic [SRC-1:0]    st_nxt,
    output logic [SRC-1:0]    rise,
    output logic [SLOTS-1:0]  to_q,
    output logic [ERR_W-1:0]  err_q,
    output logic [SRC-1:0]    clr_q
);
    logic [SRC-1:0]   wr_clr;
    logic [SLOTS-1:0] wr_to;
    logic [ERR_W-1:0] wr_err;

    assign wr_clr = stat_wr ? wdata[SRC-1:0] : '0;
    assign wr_to  = stat_wr ? wdata[TO_LSB +: SLOTS] : '0;
    assign wr_err = stat_wr ? wdata[ERR_LSB +: ERR_W] : '0;

    // Next module status: follow the request line when enabled, else hold.
    always_comb begin
        for (int i = 0; i < SRC; i++)
            st_nxt[i] = en_mask[i] ? mod_req[i] : st_q[i];
    end
    assign rise = st_nxt & ~st_q;

    // Register module status, timeout flags, error mirror and clear strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= '0;
            to_q  <= '0;
            err_q <= '0;
            clr_q <= '0;
        end else begin
            st_q  <= st_nxt;
            to_q  <= timeout_evt | (to_q & ~wr_to);
            err_q <= err_flags;
            clr_q <= wr_clr | (ack & st_q & ~edge_mask);
        end
    end

    // R4: a disabled line's status bit does not move
    p_disabled_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q ^ $past(st_q)) & ~$past(en_mask)) == '0);

    // R8: without an event or a status write the timeout flags hold
    p_timeout_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_evt == '0 && !stat_wr) |=> $stable(to_q));

    // R9: a write to the error bits does not disturb their mirror
    p_err_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_err != '0) |=> err_q == $past(err_flags));

    // R10: no qualifying acknowledge and no write gives no strobe
    p_ack_qual_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_wr && (ack & st_q & ~edge_mask) == '0) |=> clr_q == '0);
endmodule

// File: rtl/sia_merge.sv
// Host interrupt merge.
// Registers one output that is high while any level-mode status bit will be
// set, plus a one-clock pulse for each rising edge-mode status bit.
// Assumes st_nxt and rise describe the status update at this same edge.
module sia_merge
    import sia_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [SRC-1:0] st_nxt,
    input  logic [SRC-1:0] rise,
    input  logic [SRC-1:0] edge_mask,
    output logic           irq_q
);
    logic lvl_any;
    logic edge_any;

    assign lvl_any  = |(st_nxt & ~edge_mask);
    assign edge_any = |(rise & edge_mask);

    // Register the merged host interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= lvl_any | edge_any;
    end
endmodule

// File: rtl/slot_irq_merge.sv
// Four-slot interrupt aggregation controller, top level.
// Decodes the 16-bit register port, builds the status word for reads and
// ties the control, status and merge stages together.
// Assumes single-cycle register writes and combinational reads.
module slot_irq_merge
    import sia_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [SRC-1:0]    mod_req,
    input  logic [SRC-1:0]    ack_strobe,
    input  logic [SLOTS-1:0]  timeout_evt,
    input  logic [ERR_W-1:0]  err_flags,
    output logic [SRC-1:0]    mod_clr,
    output logic              host_irq
);
    logic [SLOTS-1:0][CTRL_W-1:0] ctrl_q;
    logic [SRC-1:0]               en_mask, edge_mask;
    logic [SRC-1:0]               st_q, st_nxt, rise;
    logic [SLOTS-1:0]             to_q;
    logic [ERR_W-1:0]             err_q;
    logic                         stat_wr;
    logic [DATA_W-1:0]            status_word;

    assign stat_wr     = reg_wr && reg_addr == OFF_STAT;
    assign status_word = {to_q, err_q, st_q};

    sia_ctrl_regs u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata[CTRL_W-1:0]),
        .ctrl_q    (ctrl_q),
        .en_mask   (en_mask),
        .edge_mask (edge_mask)
    );

    sia_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .stat_wr     (stat_wr),
        .wdata       (reg_wdata),
        .mod_req     (mod_req),
        .en_mask     (en_mask),
        .edge_mask   (edge_mask),
        .ack         (ack_strobe),
        .timeout_evt (timeout_evt),
        .err_flags   (err_flags),
        .st_q        (st_q),
        .st_nxt      (st_nxt),
        .rise        (rise),
        .to_q        (to_q),
        .err_q       (err_q),
        .clr_q       (mod_clr)
    );

    sia_merge u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_nxt    (st_nxt),
        .rise      (rise),
        .edge_mask (edge_mask),
        .irq_q     (host_irq)
    );

    // Read mux: status word, control bytes, zero elsewhere.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFF_STAT)
            reg_rdata = status_word;
        for (int s = 0; s < SLOTS; s++)
            if (reg_addr == ctrl_off(s))
                reg_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q[s]};
    end

    // R6: a set level-mode status bit keeps the host interrupt high
    p_level_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(st_q & ~edge_mask)) && $stable(edge_mask)) |-> host_irq);

    // R6: no module status at all means no host interrupt
    p_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == '0) |-> !host_irq);

    // R5: a pulse with no level source behind it lasts one cycle unless a new rise follows
    p_edge_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_irq && (st_q & ~edge_mask) == '0 && (en_mask & ~st_q & mod_req) == '0
         && $stable(edge_mask)) |=> !host_irq);
endmodule

// File: tb/slot_irq_merge_tb.sv
`timescale 1ns/1ps
module slot_irq_merge_tb;
    import sia_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [7:0]  mod_req = '0;
    logic [7:0]  ack_strobe = '0;
    logic [3:0]  timeout_evt = '0;
    logic [3:0]  err_flags = '0;
    logic [7:0]  mod_clr;
    logic        host_irq;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    slot_irq_merge u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .mod_req     (mod_req),
        .ack_strobe  (ack_strobe),
        .timeout_evt (timeout_evt),
        .err_flags   (err_flags),
        .mod_clr     (mod_clr),
        .host_irq    (host_irq)
    );

    // Rows: {mod_req[7:0], expected host_irq, expected status[7:0]}
    // Slot A (bits 0,1) enabled level, slot B line 0 (bit 2) enabled edge,
    // slot C (bits 4,5) disabled.
    localparam logic [16:0] VEC [0:11] = '{
        17'h00000, 17'h00301, 17'h00703, 17'h00000,
        17'h00904, 17'h00804, 17'h00000, 17'h06000,
        17'h06B05, 17'h06B05, 17'h06804, 17'h00000
    };

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3: reset state
        check("R3 host_irq after reset", {15'd0, host_irq}, 16'h0000);
        rd(8'h0C, v); check("R3 status after reset", v, 16'h0000);
        rd(8'h02, v); check("R3 ctrl A after reset", v, 16'h0000);
        check("R3 clear strobes after reset", {8'd0, mod_clr}, 16'h0000);

        // R2: control layout and readback
        wr(8'h02, 16'h00C0);
        wr(8'h04, 16'h0050);
        rd(8'h04, v); check("R2 ctrl B readback", v, 16'h0050);
        rd(8'h02, v); check("R2 ctrl A readback", v, 16'h00C0);
        rd(8'h06, v); check("R2 ctrl C untouched", v, 16'h0000);

        // R1 R4 R5 R6: vector table
        for (int i = 0; i < 12; i++) begin
            mod_req = VEC[i][16:9];
            @(negedge clk);
            check($sformatf("R5/R6 host_irq row %0d", i), {15'd0, host_irq}, {15'd0, VEC[i][8]});
            rd(8'h0C, v);
            check($sformatf("R1/R4 status row %0d", i), {8'd0, v[7:0]}, {8'd0, VEC[i][7:0]});
        end

        // R10: acknowledge only clears set level-mode sources
        mod_req = 8'h05;
        @(negedge clk);
        ack_strobe = 8'h07;
        @(negedge clk);
        ack_strobe = 8'h00;
        check("R10 ack strobe level-only", {8'd0, mod_clr}, 16'h0001);
        @(negedge clk);
        check("R10 ack strobe one cycle", {8'd0, mod_clr}, 16'h0000);

        // R7: status write raises clear strobes, leaves status alone
        wr(8'h0C, 16'h0082);
        check("R7 write clear strobe", {8'd0, mod_clr}, 16'h0082);
        rd(8'h0C, v); check("R7 status kept after write", v, 16'h0005);
        @(negedge clk);
        check("R7 strobe one cycle", {8'd0, mod_clr}, 16'h0000);

        // R4: disable slot A, drop requests, status of A holds
        wr(8'h02, 16'h0000);
        mod_req = 8'h00;
        @(negedge clk);
        rd(8'h0C, v); check("R4 disabled status held", v, 16'h0001);
        check("R6 held level keeps irq", {15'd0, host_irq}, 16'h0001);
        wr(8'h02, 16'h00C0);
        @(negedge clk);
        rd(8'h0C, v); check("R1 re-enabled line follows", v, 16'h0000);
        check("R6 irq low when none left", {15'd0, host_irq}, 16'h0000);

        // R8: timeout set and write-one clear
        timeout_evt = 4'b0010;
        @(negedge clk);
        timeout_evt = 4'b0000;
        rd(8'h0C, v); check("R8 timeout set", v, 16'h2000);
        wr(8'h0C, 16'h1000);
        rd(8'h0C, v); check("R8 other timeout write", v, 16'h2000);
        wr(8'h0C, 16'h2000);
        rd(8'h0C, v); check("R8 timeout cleared", v, 16'h0000);

        // R9: error mirror ignores writes
        err_flags = 4'b0101;
        @(negedge clk);
        rd(8'h0C, v); check("R9 error mirror", v, 16'h0500);
        wr(8'h0C, 16'h0F00);
        rd(8'h0C, v); check("R9 error write ignored", v, 16'h0500);
        err_flags = 4'b0000;
        @(negedge clk);

        // R11: revision, reset slot and unmapped offsets
        wr(8'h00, 16'hFFFF);
        rd(8'h00, v); check("R11 revision reads zero", v, 16'h0000);
        wr(8'h0A, 16'hFFFF);
        rd(8'h0A, v); check("R11 reset offset reads zero", v, 16'h0000);
        rd(8'h0E, v); check("R11 unmapped reads zero", v, 16'h0000);
        rd(8'h02, v); check("R11 writes left ctrl alone", v, 16'h00C0);

        // R3: reset mid-run with a level source pending
        mod_req = 8'h01;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        mod_req = 8'h00;
        check("R3 irq low after reset", {15'd0, host_irq}, 16'h0000);
        rd(8'h02, v); check("R3 ctrl cleared by reset", v, 16'h0000);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule